// File: doc/BRIEF.md
# Bitstream Delay Line Controller

This block delays a one-bit audio bitstream by a chosen number of sample ticks. Each incoming bit is stored in an internal first-in first-out buffer. After a reset, the buffer only fills at first. Reading starts once a selected condition first becomes true. From then on, every tick reads the oldest bit and writes a new one, so the number of bits held, and with it the delay, stays fixed.

The delay therefore depends only on when the first read happens relative to reset. There are four read-start sources:

- a small bit of a fill counter, for flanging;
- a larger bit of the same counter, for chorus;
- the buffer-full flag, for the longest delay;
- the half-full flag, for a mid-length delay.

The source is captured while reset is held. A delay that is already running cannot be disturbed by a change of the select pins.

The delay in seconds is the delay in stages divided by the tick rate. For example, 4096 stages at a 256 kHz tick gives 16 ms.

Top module: `bsdl_top`

## Requirements
- R1: While `rst` is high, nothing is stored or read, even if `tick` pulses. In the cycle after any cycle with `rst` high, `dout`, `full` and `half` are 0 and the buffer is empty.
- R2: A bit is written only in a cycle where `tick` is high. In cycles without `tick`, `dout`, `full` and `half` keep their values.
- R3: With `mode` = 2'b00 at reset, reading starts once 2^SHORT_TAP bits (16 by default) have been written. The bit written on tick j then appears on `dout` right after tick j+16.
- R4: With `mode` = 2'b01 at reset, reading starts after 2^LONG_TAP writes (512 by default), giving a delay of 512 ticks.
- R5: With `mode` = 2'b10 at reset, reading starts once the buffer is full. The delay is DEPTH ticks (4096 by default). `full` rises after the DEPTH-th write and then stays high, because each later tick reads one bit before writing one. The count of stored bits never exceeds DEPTH.
- R6: With `mode` = 2'b11 at reset, reading starts once DEPTH/2 bits are stored, giving a delay of DEPTH/2 ticks. `half` is high exactly when at least DEPTH/2 bits are stored.
- R7: `dout` is 0 from reset until the first read.
- R8: Once reading has started, it continues on every tick until the next reset. This holds even when the fill counter wraps and its selected bit returns to 0.
- R9: A change on `mode` after reset has been released has no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also latches `mode` |
| tick | input | 1 | Sample strobe, one cycle wide |
| din | input | 1 | Serial bitstream input, taken when `tick` is high |
| mode | input | 2 | Read-start source: 00 short count, 01 long count, 10 full, 11 half-full |
| dout | output | 1 | Delayed bitstream, registered, updated on read ticks |
| full | output | 1 | Buffer holds DEPTH bits |
| half | output | 1 | Buffer holds at least DEPTH/2 bits |

## Verification
Each source is run long enough to cross its start threshold. The check falls on the exact tick where the first stored bit must emerge, so a read that starts one tick early or late shifts every output and gives the wrong delay.

Short-count and long-count runs continue past the point where the fill counter wraps. A design that reads the counter bit directly, instead of latching the start, would stall there.

The full-mode run holds the buffer at capacity. A design that wrote before reading in the same tick would overflow or lose a bit, and `full` would drop.

Three further stimuli target specific faults:

- Ticks pulsed while reset is held would shift the delay if they were stored.
- Mode changes in mid-run would alter the delay if they were not deferred to the next reset.
- Gaps between ticks would move `dout` if the design did not hold it between ticks.

// File: rtl/bsdl_pkg.sv
package bsdl_pkg;
   typedef enum logic [1:0] {
      SRC_SHORT = 2'b00,
      SRC_LONG  = 2'b01,
      SRC_FULL  = 2'b10,
      SRC_HALF  = 2'b11
   } rd_src_e;
endpackage

// File: rtl/bsdl_ram.sv
// One-bit storage array with a registered read port.
// A read and a write in the same edge return the old contents (read first).
module bsdl_ram #(
   parameter int DEPTH = 4096,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic          wbit,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output logic          rbit
);
   logic mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wbit;
   end

   always_ff @(posedge clk) begin
      if (rst)     rbit <= 1'b0;
      else if (re) rbit <= mem[raddr];
   end
endmodule

// File: rtl/bsdl_ptrs.sv
// Write/read pointers, stored-bit count and level flags.
module bsdl_ptrs #(
   parameter int DEPTH = 4096,
   localparam int AW = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          wr,
   input  logic          rd,
   output logic [AW-1:0] wptr,
   output logic [AW-1:0] rptr,
   output logic [AW:0]   occ,
   output logic          full,
   output logic          half
);
   localparam logic [AW:0]   CAP     = (AW+1)'(DEPTH);
   localparam logic [AW:0]   HALFCAP = (AW+1)'(DEPTH / 2);
   localparam logic [AW:0]   ONE_O   = (AW+1)'(1);
   localparam logic [AW-1:0] ONE_P   = AW'(1);

   always_ff @(posedge clk) begin
      if (rst) begin
         wptr <= '0;
         rptr <= '0;
         occ  <= '0;
      end else begin
         if (wr) wptr <= wptr + ONE_P;
         if (rd) rptr <= rptr + ONE_P;
         if (wr && !rd)      occ <= occ + ONE_O;
         else if (rd && !wr) occ <= occ - ONE_O;
      end
   end

   assign full = (occ == CAP);
   assign half = (occ >= HALFCAP);
endmodule

// File: rtl/bsdl_gate.sv
// Strobe gating, fill counter, latched source select and sticky read-run flag.
module bsdl_gate
   import bsdl_pkg::*;
#(
   parameter int SHORT_TAP = 4,
   parameter int LONG_TAP  = 9,
   localparam int CW = LONG_TAP + 1
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       tick,
   input  logic [1:0] mode,
   input  logic       full,
   input  logic       half,
   output logic       wr,
   output logic       rd,
   output logic       run
);
   rd_src_e       src_q;
   logic [CW-1:0] fill;
   logic          start;

   always_ff @(posedge clk) begin
      if (rst) src_q <= rd_src_e'(mode);
   end

   always_ff @(posedge clk) begin
      if (rst)     fill <= '0;
      else if (wr) fill <= fill + CW'(1);
   end

   always_comb begin
      case (src_q)
         SRC_SHORT: start = fill[SHORT_TAP];
         SRC_LONG:  start = fill[LONG_TAP];
         SRC_FULL:  start = full;
         SRC_HALF:  start = half;
         default:   start = 1'b0;
      endcase
   end

   assign wr = tick & ~rst;
   assign rd = wr & (run | start);

   always_ff @(posedge clk) begin
      if (rst)     run <= 1'b0;
      else if (rd) run <= 1'b1;
   end
endmodule

// File: rtl/bsdl_top.sv
module bsdl_top #(
   parameter int DEPTH     = 4096,
   parameter int SHORT_TAP = 4,
   parameter int LONG_TAP  = 9
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       tick,
   input  logic       din,
   input  logic [1:0] mode,
   output logic       dout,
   output logic       full,
   output logic       half
);
   localparam int AW = $clog2(DEPTH);

   generate
      if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 4");
      end
      if (SHORT_TAP < 0 || SHORT_TAP >= LONG_TAP) begin : g_bad_taps
         $error("SHORT_TAP must be below LONG_TAP");
      end
      if ((64'd1 << LONG_TAP) > 64'(DEPTH)) begin : g_bad_long
         $error("2**LONG_TAP must not exceed DEPTH");
      end
   endgenerate

   logic          wr, rd, run_q;
   logic [AW-1:0] wptr, rptr;
   logic [AW:0]   occ;

   bsdl_gate #(.SHORT_TAP(SHORT_TAP), .LONG_TAP(LONG_TAP)) u_gate (
      .clk(clk), .rst(rst), .tick(tick), .mode(mode),
      .full(full), .half(half), .wr(wr), .rd(rd), .run(run_q)
   );

   bsdl_ptrs #(.DEPTH(DEPTH)) u_ptrs (
      .clk(clk), .rst(rst), .wr(wr), .rd(rd),
      .wptr(wptr), .rptr(rptr), .occ(occ), .full(full), .half(half)
   );

   bsdl_ram #(.DEPTH(DEPTH)) u_ram (
      .clk(clk), .rst(rst), .we(wr), .waddr(wptr), .wbit(din),
      .re(rd), .raddr(rptr), .rbit(dout)
   );
endmodule

// File: rtl/bsdl_chk.sv
module bsdl_chk #(
   parameter int DEPTH = 4096,
   localparam int AW = $clog2(DEPTH)
) (
   input logic        clk,
   input logic        rst,
   input logic        tick,
   input logic        rd,
   input logic        run,
   input logic [AW:0] occ,
   input logic        dout,
   input logic        full,
   input logic        half
);
   AST_QUIET_AFTER_RESET: assert property (@(posedge clk)
      rst |=> (occ == '0) && !dout && !full && !half);                      // R1
   AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
      !tick |=> $stable(dout) && $stable(occ));                             // R2
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
      occ <= (AW+1)'(DEPTH));                                               // R5
   AST_PAIRED_KEEPS_LEVEL: assert property (@(posedge clk) disable iff (rst)
      rd |=> occ == $past(occ));                                            // R5
   AST_FULL_STAYS: assert property (@(posedge clk) disable iff (rst)
      full |=> full);                                                       // R5
   AST_ZERO_BEFORE_READ: assert property (@(posedge clk) disable iff (rst)
      !run |-> !dout);                                                      // R7
   AST_RUN_STICKY: assert property (@(posedge clk) disable iff (rst)
      run |=> run);                                                         // R8
endmodule

bind bsdl_top bsdl_chk #(.DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst(rst), .tick(tick), .rd(rd), .run(run_q),
   .occ(occ), .dout(dout), .full(full), .half(half)
);

// File: tb/sim_bsdl_top.sv
module sim_bsdl_top;
   localparam int DEPTH = 4096;

   typedef struct packed {
      logic [1:0]  m;
      logic [15:0] dly;
      logic [15:0] n;
   } vec_t;

   localparam vec_t VT [4] = '{
      '{2'b00, 16'd16,   16'd100},
      '{2'b01, 16'd512,  16'd1100},
      '{2'b10, 16'd4096, 16'd4200},
      '{2'b11, 16'd2048, 16'd2200}
   };

   logic clk = 1'b0, rst = 1'b1, tick = 1'b0, din = 1'b0;
   logic [1:0] mode = 2'b00;
   logic dout, full, half;

   int unsigned n_chk = 0, n_bad = 0, k = 0;
   bit hist [8192];
   logic [15:0] lfsr = 16'hACE1;

   always #4 clk = ~clk;

   bsdl_top u0 (.clk(clk), .rst(rst), .tick(tick), .din(din), .mode(mode),
                .dout(dout), .full(full), .half(half));

   task automatic chk(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0b expected=%0b (tick %0d)", req, act, exp, k);
      end
   endtask

   function automatic logic exp_out(input int unsigned dly);
      return (k > dly) ? hist[k - dly] : 1'b0;
   endfunction

   function automatic string tag_of(input logic [1:0] m);
      case (m)
         2'b00:   return "R3";
         2'b01:   return "R4";
         2'b10:   return "R5";
         default: return "R6";
      endcase
   endfunction

   task automatic check_all(input string req, input int unsigned dly, input int unsigned lvl_cap);
      int unsigned lvl;
      lvl = (k < lvl_cap) ? k : lvl_cap;
      chk((k <= dly) ? "R7" : req, dout, exp_out(dly));
      chk("R5", full, lvl == DEPTH);
      chk("R6", half, lvl >= DEPTH / 2);
   endtask

   // called at a falling edge; returns at the next falling edge
   task automatic step(input logic t);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      din  = lfsr[0];
      tick = t;
      if (t) begin
         k++;
         hist[k] = lfsr[0];
      end
      @(posedge clk);
      @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic do_reset(input logic [1:0] m);
      rst  = 1'b1;
      tick = 1'b0;
      mode = m;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      k   = 0;
   endtask

   task automatic report;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      report();
      $finish;
   end

   initial begin
      @(negedge clk);
      // vector table: one run per read-start source
      for (int i = 0; i < 4; i++) begin
         do_reset(VT[i].m);
         chk("R1", dout, 1'b0);
         chk("R1", full, 1'b0);
         chk("R1", half, 1'b0);
         for (int j = 0; j < int'(VT[i].n); j++) begin
            step(1'b1);
            // R8: short/long runs pass the fill counter wrap
            check_all(tag_of(VT[i].m), VT[i].dly,
                      (VT[i].m == 2'b10) ? DEPTH :
                      (VT[i].m == 2'b11) ? DEPTH / 2 : int'(VT[i].dly));
         end
      end

      // R1: ticks during reset must not be stored
      rst = 1'b1;
      mode = 2'b00;
      for (int j = 0; j < 5; j++) begin
         din = 1'b1;
         tick = 1'b1;
         @(posedge clk);
         @(negedge clk);
         chk("R1", dout, 1'b0);
         chk("R1", full, 1'b0);
      end
      tick = 1'b0;
      rst = 1'b0;
      k = 0;
      for (int j = 0; j < 40; j++) begin
         step(1'b1);
         chk("R1", dout, exp_out(16));
      end

      // R2: gaps between ticks leave outputs unchanged
      do_reset(2'b00);
      for (int j = 0; j < 80; j++) begin
         step(j % 2 == 0);
         chk("R2", dout, exp_out(16));
         chk("R2", half, 1'b0);
      end

      // R9: mode change in mid-run ignored until next reset
      do_reset(2'b00);
      for (int j = 0; j < 30; j++) step(1'b1);
      mode = 2'b10;
      for (int j = 0; j < 40; j++) begin
         step(1'b1);
         chk("R9", dout, exp_out(16));
      end
      do_reset(2'b01);
      mode = 2'b00;
      for (int j = 0; j < 530; j++) begin
         step(1'b1);
         if (k >= 510) chk("R9", dout, exp_out(512));
      end

      report();
      $finish;
   end
endmodule